// File: doc/BRIEF.md
# Deglitching DAC Strobe Sequencer

This block sequences one update of a current-output DAC that is followed by a track/hold stage. A rising edge on the strobe input starts an update. The block waits a fixed number of reference-clock cycles and then drives the hold control high, which holds the amplifier at its last value. A fixed number of cycles after that, it raises the register load pulse. At that edge the whole input word is captured at once into the register that feeds the DAC. The DAC therefore changes its code only while the output stage is held.

Both pulses stay high for the same programmable number of cycles. The hold pulse then drops, the stage returns to track, and the load pulse ends the same offset later. Because the DAC transient is always hidden inside a hold window of the same shape, the residual disturbance at the output has the same size at every update. It does not depend on which code was written.

All delays and widths are counted in cycles of the reference clock. The hold-width setting is clamped into a legal window. At a 5 ns clock, the default window of 6 to 20 cycles spans about 30 to 100 ns, and a setting of 17 gives about 85 ns.

The sequencer has five states. IDLE (track, not busy) leaves on a strobe edge for WAIT. WAIT runs DELAY_CYC cycles and then moves to LEAD, where hold is high. LEAD runs LOAD_OFS cycles and then moves to BOTH, where hold and load are high and the word is captured on entry. BOTH lasts until the hold width is used up and then moves to TAIL, where only load is high. TAIL runs LOAD_OFS cycles and then returns to IDLE. Every other state stays where it is until its count expires.

Top module: `dglt_strobe_seq`

## Requirements
- R1: While reset is high and after it is released, hold, load and busy are 0 and the DAC word is all zeros, until a strobe edge is seen.
- R2: An update starts when strobe is sampled 1 at a clock edge where it was sampled 0 at the previous edge and the block is in IDLE. Busy is 1 from that edge on.
- R3: Hold rises exactly DELAY_CYC clock edges after the start edge. Hold = 1 means hold (switch open) and 0 means track.
- R4: The load pulse rises exactly LOAD_OFS edges after hold rises.
- R5: The DAC word changes only at the edge where load rises. At that edge it takes, in one step, all bits of the data input sampled at that edge.
- R6: Hold stays high for exactly the effective width in cycles, and load stays high for the same number of cycles.
- R7: The effective width is the hold-width input clamped to the range HOLD_MIN..HOLD_MAX. A setting below the range gives HOLD_MIN and one above it gives HOLD_MAX.
- R8: A strobe edge seen while busy is ignored, and a strobe held high starts only one update.
- R9: Busy falls at the edge where load falls, so the block is back in IDLE. A strobe edge at the next edge starts a new update.
- R10: The hold-width input is sampled only at the start edge. Changing it during an update has no effect on that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| strobe | input | 1 | Update request, rising edge active |
| data_in | input | DATA_W | Word for the DAC, sampled when load rises |
| hold_width | input | HW_W | Requested hold width in clock cycles |
| hold_ctl | output | 1 | 1 = hold, 0 = track |
| load_pulse | output | 1 | Register load pulse for the DAC word |
| dac_word | output | DATA_W | Registered word driving the DAC |
| busy | output | 1 | Update in progress |

## Verification
A single isolated strobe with the default width checks the basic delay, offset and width chain. Width settings of 0, HOLD_MIN, HOLD_MAX and the maximum input value check that clamping happens at both ends and not one cycle off. Strobes repeated inside an update, a strobe held high for many cycles, and a strobe placed on the first idle cycle separate the cases where a request is ignored from those where it is accepted. Data that changes on every cycle around the load edge, with all-zeros, all-ones and the codes on either side of mid-scale, shows that the captured word is exactly the value present at the load edge.

// File: rtl/dglt_pkg.sv
package dglt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_BOTH,
        ST_TAIL
    } seq_state_t;
endpackage

// File: rtl/dglt_rise_det.sv
module dglt_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dglt_width_clamp.sv
module dglt_width_clamp #(
    parameter int HW_W     = 7,
    parameter int HOLD_MIN = 6,
    parameter int HOLD_MAX = 20
) (
    input  logic [HW_W-1:0] raw,
    output logic [HW_W-1:0] eff
);
    localparam logic [HW_W-1:0] LO = HW_W'(HOLD_MIN);
    localparam logic [HW_W-1:0] HI = HW_W'(HOLD_MAX);

    always_comb begin
        if (raw < LO)      eff = LO;
        else if (raw > HI) eff = HI;
        else               eff = raw;
    end
endmodule

// File: rtl/dglt_word_reg.sv
module dglt_word_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst)          q[b] <= 1'b0;
            else if (load_en) q[b] <= d[b];
        end
    end
endmodule

// File: rtl/dglt_strobe_seq.sv
module dglt_strobe_seq #(
    parameter int DATA_W    = 12,
    parameter int HW_W      = 7,
    parameter int DELAY_CYC = 11,
    parameter int LOAD_OFS  = 2,
    parameter int HOLD_MIN  = 6,
    parameter int HOLD_MAX  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic [HW_W-1:0]   hold_width,
    output logic              hold_ctl,
    output logic              load_pulse,
    output logic [DATA_W-1:0] dac_word,
    output logic              busy
);
    import dglt_pkg::*;

    localparam int CNT_W = $clog2(DELAY_CYC + HOLD_MAX + 2);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] OFS_LAST  = CNT_W'(LOAD_OFS - 1);
    localparam logic [CNT_W-1:0] OFS_CNT   = CNT_W'(LOAD_OFS);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] width_q;
    logic [HW_W-1:0]  width_eff;
    logic             start;
    logic             step_done;
    logic             capture;

    dglt_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (strobe),
        .rise (start)
    );

    dglt_width_clamp #(
        .HW_W     (HW_W),
        .HOLD_MIN (HOLD_MIN),
        .HOLD_MAX (HOLD_MAX)
    ) u_clamp (
        .raw (hold_width),
        .eff (width_eff)
    );

    dglt_word_reg #(
        .DATA_W (DATA_W)
    ) u_word (
        .clk     (clk),
        .rst     (rst),
        .load_en (capture),
        .d       (data_in),
        .q       (dac_word)
    );

    // Count limit for the state currently running
    always_comb begin
        unique case (state)
            ST_WAIT: step_done = (cnt == WAIT_LAST);
            ST_LEAD: step_done = (cnt == OFS_LAST);
            ST_BOTH: step_done = (cnt == width_q - OFS_CNT - 1'b1);
            ST_TAIL: step_done = (cnt == OFS_LAST);
            default: step_done = 1'b0;
        endcase
    end

    // Transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (start) state_nx = ST_WAIT;
            end
            ST_WAIT: if (step_done) begin state_nx = ST_LEAD; cnt_nx = '0; end
            ST_LEAD: if (step_done) begin state_nx = ST_BOTH; cnt_nx = '0; end
            ST_BOTH: if (step_done) begin state_nx = ST_TAIL; cnt_nx = '0; end
            ST_TAIL: if (step_done) begin state_nx = ST_IDLE; cnt_nx = '0; end
            default: begin state_nx = ST_IDLE; cnt_nx = '0; end
        endcase
    end

    assign capture = (state == ST_LEAD) && step_done;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            width_q <= CNT_W'(HOLD_MIN);
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == ST_IDLE && start) width_q <= CNT_W'(width_eff);
        end
    end

    // Outputs
    always_comb begin
        hold_ctl   = 1'b0;
        load_pulse = 1'b0;
        busy       = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: ;
            ST_LEAD: hold_ctl = 1'b1;
            ST_BOTH: begin hold_ctl = 1'b1; load_pulse = 1'b1; end
            ST_TAIL: load_pulse = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dglt_strobe_seq_chk.sv
module dglt_strobe_seq_chk #(
    parameter int DATA_W   = 12,
    parameter int HOLD_MIN = 6,
    parameter int HOLD_MAX = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input logic              hold_ctl,
    input logic              load_pulse,
    input logic              busy,
    input logic [DATA_W-1:0] dac_word
);
    localparam int RUN_W = $clog2(HOLD_MAX + 2);
    logic [RUN_W-1:0] hold_run;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           hold_run <= '0;
        else if (hold_ctl) hold_run <= hold_run + 1'b1;
        else               hold_run <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!hold_ctl && !load_pulse && !busy && dac_word == '0));

    assert_busy_from_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(strobe));

    assert_load_inside_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(load_pulse) |-> (hold_ctl && $past(hold_ctl)));

    assert_word_moves_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        !$rose(load_pulse) |-> $stable(dac_word));

    assert_hold_not_long_R6: assert property (@(posedge clk) disable iff (rst)
        hold_ctl |-> (hold_run < RUN_W'(HOLD_MAX)));

    assert_hold_width_range_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ctl) |-> (hold_run >= RUN_W'(HOLD_MIN) && hold_run <= RUN_W'(HOLD_MAX)));

    assert_pulses_need_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_ctl || load_pulse) |-> busy);
endmodule

bind dglt_strobe_seq dglt_strobe_seq_chk #(
    .DATA_W   (DATA_W),
    .HOLD_MIN (HOLD_MIN),
    .HOLD_MAX (HOLD_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .hold_ctl   (hold_ctl),
    .load_pulse (load_pulse),
    .busy       (busy),
    .dac_word   (dac_word)
);

// File: tb/dglt_strobe_seq_bench.sv
`timescale 1ns/1ps
module dglt_strobe_seq_bench;
    localparam int DW = 12, HWW = 7, D = 11, L = 2, HMIN = 6, HMAX = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic [DW-1:0]  data_in = 12'h5A3;
    logic [HWW-1:0] hold_width = 7'd17;
    logic hold_ctl, load_pulse, busy;
    logic [DW-1:0] dac_word;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dglt_strobe_seq #(.DATA_W(DW), .HW_W(HWW), .DELAY_CYC(D), .LOAD_OFS(L),
                      .HOLD_MIN(HMIN), .HOLD_MAX(HMAX)) u_dglt_strobe_seq (
        .clk(clk), .rst(rst), .strobe(strobe), .data_in(data_in),
        .hold_width(hold_width), .hold_ctl(hold_ctl), .load_pulse(load_pulse),
        .dac_word(dac_word), .busy(busy));

    // Behavioural reference: t = cycles since start edge, -1 when idle
    int t = -1, mhw = HMIN;
    logic prev = 1'b0;
    logic [DW-1:0] edac = '0;

    function automatic int clampw(int v);
        return (v < HMIN) ? HMIN : (v > HMAX) ? HMAX : v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            t = -1; edac = '0; prev = 1'b0;
        end else begin
            logic rise;
            rise = strobe && !prev;
            prev = strobe;
            if (t >= 0) begin
                t++;
                if (t == D + mhw + L) t = -1;
            end else if (rise) begin
                t = 0; mhw = clampw(int'(hold_width));
            end
            if (t == D + L) edac = data_in;
        end
    end

    task automatic chk(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        logic eb, eh, el;
        eb = (t >= 0);
        eh = (t >= D) && (t < D + mhw);
        el = (t >= D + L) && (t < D + mhw + L);
        chk("busy R2/R9", DW'(busy), DW'(eb));
        chk("hold R3/R6", DW'(hold_ctl), DW'(eh));
        chk("load R4/R6", DW'(load_pulse), DW'(el));
        chk("dac word R5", dac_word, edac);
    end

    always @(posedge clk) if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog R2: got hung run expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int n);
        strobe = 1'b1; step(n); strobe = 1'b0;
    endtask

    // One update, counting hold and load cycles against the clamped width
    task automatic run_seq(int hw, logic [DW-1:0] w, string rq);
        int nh = 0, nl = 0;
        tag = rq; hold_width = HWW'(hw); data_in = w;
        pulse(1);
        while (busy) begin
            if (hold_ctl) nh++;
            if (load_pulse) nl++;
            step(1);
        end
        checks++;
        if (nh != clampw(hw) || nl != clampw(hw)) begin
            errors++;
            $display("FAIL %s width: got hold %0d load %0d expected %0d", rq, nh, nl, clampw(hw));
        end
        step(3);
    endtask

    initial begin
        // R1: reset quiet with nonzero data present
        tag = "R1";
        step(4);
        rst = 1'b0;
        step(3);
        // R2 R3 R4 R5 R6: default width
        run_seq(17, 12'hA5C, "R6");
        // R7: clamp at both ends and boundaries
        run_seq(0, 12'h000, "R7");
        run_seq(HMIN, 12'hFFF, "R7");
        run_seq(HMAX, 12'h800, "R7");
        run_seq(127, 12'h7FF, "R7");
        run_seq(HMIN + 1, 12'h001, "R7");
        // R8: strobes during an update are ignored
        tag = "R8"; hold_width = 7'd10; data_in = 12'h321;
        pulse(1); step(4); pulse(1); step(12); pulse(2); step(40);
        // R8: strobe held high starts a single update
        pulse(60); step(5);
        // R10: width changed mid-update has no effect
        tag = "R10"; hold_width = 7'd8;
        pulse(1); step(3); hold_width = 7'd20; step(40);
        // R5: data changing every cycle around the load edge
        tag = "R5"; hold_width = 7'd12;
        pulse(1);
        for (int i = 0; i < 40; i++) begin data_in = DW'(12'h100 + i * 37); step(1); end
        // R9: strobe accepted on the first idle cycle
        tag = "R9"; hold_width = 7'd6; data_in = 12'hC3C;
        pulse(1);
        while (busy) step(1);
        data_in = 12'h3C3; pulse(1);
        while (busy) step(1);
        step(5);
        // R1: reset mid-update clears everything
        tag = "R1"; pulse(1); step(D + 4);
        rst = 1'b1; step(3); rst = 1'b0; step(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule